// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Dual Role and Bus-Conflict Detection

This block moves one byte at a time over a four-wire SPI bus and can take either side of the link. In the master role it generates the serial clock from the system clock. It exchanges eight bits in each direction at once, most significant bit first. The clock idles low, outgoing data changes on the falling edge and incoming data is taken on the rising edge. In the slave role it follows a clock from another device. It shifts only while its active-low select input is low, and it drives its serial output only during that time. Bus pins are separate input, output and output-enable signals, so the pads sit outside the block.

In the master role the select pin has three uses, chosen by two controls. It can be a conflict-detect input, a driven select output, or left to general-purpose use. When another master pulls the select pin low while conflict detection is enabled, the block sets a sticky fault flag. It then drops to the slave role at once and releases the clock and MOSI drivers. When the select pin is a driven output, it can either stay low throughout, or rise between bytes and fall again for each new transfer.

The state machine has six states. `ST_IDLE` waits for work. `ST_M_LEAD` holds select low for one half period before the first rising edge. `ST_M_HIGH` and `ST_M_LOW` are the two clock phases. `ST_M_TAIL` is the last low half period. `ST_S_SEL` is the slave role with select asserted. The transitions are:
- `ST_IDLE`→`ST_M_LEAD` on a start strobe in the master role.
- `ST_IDLE`→`ST_S_SEL` when the synchronised select is low in the slave role.
- `ST_M_LEAD`→`ST_M_HIGH` and `ST_M_LOW`→`ST_M_HIGH` at the end of each half period.
- `ST_M_HIGH`→`ST_M_LOW` after rising edges one to seven.
- `ST_M_HIGH`→`ST_M_TAIL` after the eighth rising edge.
- `ST_M_TAIL`→`ST_IDLE` with the done pulse.
- Any master state→`ST_IDLE` when the master role is lost.
- `ST_S_SEL`→`ST_IDLE` when select rises or the role becomes master.

Top module: `spi_duplex_ctrl`

## Requirements
- R1: In the master role, with the clock idle at 0, a start strobe produces exactly eight rising edges on `sclk_o`, and `sclk_o` is low whenever `busy` is low.
- R2: The high and low phases of the master clock, and the lead-in before the first rising edge, each last 2^`div_sel` system clocks. A master transfer therefore keeps `busy` high for 17·2^`div_sel` cycles.
- R3: In the master role, `mosi_o` changes only while `sclk_o` is low. It carries `tx_byte` most significant bit first.
- R4: After the eighth sampling edge, `rx_byte` holds the eight bits received most significant bit first, and `done` is high for exactly one cycle.
- R5: A start strobe during a transfer is ignored. `busy` stays high until that byte completes with `done`.
- R6: In the slave role with `ss_n_i` low, the block samples `mosi_i` on rising `sclk_i` edges, presents `tx_byte` MSB first on `miso_o`, and raises `done` after eight rising edges. `miso_oe` is high only while the slave is selected.
- R7: In the slave role with `ss_n_i` high, edges on `sclk_i` have no effect: no `done`, `rx_byte` unchanged, `miso_oe` low.
- R8: In the master role with `mf_disable`=1 and `ss_out_en`=0, `ss_n_oe` is 0, and a low `ss_n_i` neither sets `fault` nor changes the role.
- R9: In the master role with `mf_disable`=0, `ss_n_oe` is 0 and `ss_n_i` is an input. A low level there sets `fault` within three cycles, ends the master role (`sclk_oe`=`mosi_oe`=0) and aborts any transfer without `done`.
- R10: `fault` stays set until a `fault_clr` strobe. The master role then returns if `master_en` is still 1.
- R11: In the master role with `mf_disable`=1, `ss_out_en`=1 and `auto_ss`=0, `ss_n_oe`=1 and `ss_n_o` is held low continuously, idle or not.
- R12: With `auto_ss`=1 in the same select-output setup, `ss_n_o` is low from the lead-in to the end of the last half period, and high when idle and in the `done` cycle.
- R13: When `master_en`=0, a start strobe is ignored: `busy` stays low and `sclk_oe` stays 0.
- R14: After reset the block is idle: `busy`, `done`, `fault` and `rx_byte` are 0, and `ss_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Requests the master role |
| mf_disable | input | 1 | 1 = no conflict detection on select in the master role |
| ss_out_en | input | 1 | With `mf_disable`=1, drive select as an output |
| auto_ss | input | 1 | Raise select between bytes when it is driven |
| div_sel | input | DIV_W | Half-period exponent: 2^`div_sel` system clocks |
| start | input | 1 | Starts a master transfer |
| tx_byte | input | DATA_W | Byte to send |
| fault_clr | input | 1 | Clears the fault flag |
| rx_byte | output | DATA_W | Last byte received |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Sticky bus-conflict flag |
| sclk_i | input | 1 | Bus clock input (slave role) |
| sclk_o | output | 1 | Bus clock output (master role) |
| sclk_oe | output | 1 | Bus clock drive enable |
| mosi_i | input | 1 | Serial data in (slave role) |
| mosi_o | output | 1 | Serial data out (master role) |
| mosi_oe | output | 1 | MOSI drive enable |
| miso_i | input | 1 | Serial data in (master role) |
| miso_o | output | 1 | Serial data out (slave role) |
| miso_oe | output | 1 | MISO drive enable |
| ss_n_i | input | 1 | Select pin input |
| ss_n_o | output | 1 | Select pin output value |
| ss_n_oe | output | 1 | Select pin drive enable |

## Verification
The bench keeps the default `DATA_W`=8 and `DIV_W`=3. It varies `div_sel` from 0 to 3, which gives half periods of 1, 2, 4 and 8 system clocks. At 0 the clock runs at half the system rate, so every phase lasts a single cycle and the 17-cycle transfer length is checked at its tightest. The longer settings leave room to inject a second start, or a select pulled low, in the middle of a byte. The slave role is driven with a bus clock eight times slower than the system half-period, so the two-stage synchroniser latency stays inside each phase.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_M_LEAD,
        ST_M_HIGH,
        ST_M_LOW,
        ST_M_TAIL,
        ST_S_SEL
    } spi_state_e;

    // synchroniser depth for bus inputs in the slave role
    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   half_len;

    always_comb begin
        half_len = (CNT_W+1)'(1) << div_sel;
        tick     = run && ({1'b0, cnt_q} == half_len - (CNT_W+1)'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int         WIDTH  = 3,
    parameter int         STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= pin_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/spi_ctrl_fsm.sv
module spi_ctrl_fsm
    import spi_duplex_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              miso_i,
    input  logic              sel_act,
    input  logic              s_sclk,
    input  logic              s_mosi,
    output logic              run,
    output logic              busy,
    output logic              done,
    output logic              sclk_q,
    output logic              out_bit,
    output logic              slave_on,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int BW = $clog2(DATA_W + 1);
    localparam logic [BW-1:0] LAST_RISE = BW'(DATA_W);
    localparam logic [BW-1:0] SLV_LAST  = BW'(DATA_W - 1);

    spi_state_e        state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic              samp_q;
    logic [BW-1:0]     bit_cnt_q;
    logic              sclk_d_q;
    logic              s_rise, s_fall;
    logic              mst_state;

    assign s_rise = s_sclk & ~sclk_d_q;
    assign s_fall = ~s_sclk & sclk_d_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (is_master) begin
                    if (start) state_d = ST_M_LEAD;
                end else if (sel_act) begin
                    state_d = ST_S_SEL;
                end
            end
            ST_M_LEAD: begin
                if (!is_master)  state_d = ST_IDLE;
                else if (tick)   state_d = ST_M_HIGH;
            end
            ST_M_HIGH: begin
                if (!is_master)  state_d = ST_IDLE;
                else if (tick)   state_d = (bit_cnt_q == LAST_RISE) ? ST_M_TAIL : ST_M_LOW;
            end
            ST_M_LOW: begin
                if (!is_master)  state_d = ST_IDLE;
                else if (tick)   state_d = ST_M_HIGH;
            end
            ST_M_TAIL: begin
                if (!is_master || tick) state_d = ST_IDLE;
            end
            ST_S_SEL: begin
                if (is_master || !sel_act) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            samp_q    <= 1'b0;
            bit_cnt_q <= '0;
            rx_byte   <= '0;
            done      <= 1'b0;
            sclk_q    <= 1'b0;
            sclk_d_q  <= 1'b0;
        end else begin
            done     <= 1'b0;
            sclk_d_q <= s_sclk;
            unique case (state_q)
                ST_IDLE: begin
                    bit_cnt_q <= '0;
                    sclk_q    <= 1'b0;
                    if (state_d != ST_IDLE) shreg_q <= tx_byte;
                end
                ST_M_LEAD, ST_M_LOW: begin
                    if (state_d == ST_M_HIGH) begin
                        sclk_q    <= 1'b1;
                        samp_q    <= miso_i;
                        bit_cnt_q <= bit_cnt_q + BW'(1);
                    end else if (state_d == ST_IDLE) begin
                        sclk_q <= 1'b0;
                    end
                end
                ST_M_HIGH: begin
                    if (state_d != ST_M_HIGH) sclk_q <= 1'b0;
                    if (state_d == ST_M_LOW)
                        shreg_q <= {shreg_q[DATA_W-2:0], samp_q};
                end
                ST_M_TAIL: begin
                    sclk_q <= 1'b0;
                    if (is_master && tick) begin
                        rx_byte   <= {shreg_q[DATA_W-2:0], samp_q};
                        done      <= 1'b1;
                        bit_cnt_q <= '0;
                    end
                end
                ST_S_SEL: begin
                    if (s_rise) begin
                        if (bit_cnt_q == SLV_LAST) begin
                            rx_byte   <= {shreg_q[DATA_W-2:0], s_mosi};
                            done      <= 1'b1;
                            bit_cnt_q <= '0;
                            shreg_q   <= tx_byte;
                        end else begin
                            samp_q    <= s_mosi;
                            bit_cnt_q <= bit_cnt_q + BW'(1);
                        end
                    end else if (s_fall && bit_cnt_q != '0) begin
                        shreg_q <= {shreg_q[DATA_W-2:0], samp_q};
                    end
                end
                default: sclk_q <= 1'b0;
            endcase
        end
    end

    always_comb begin
        mst_state = (state_q == ST_M_LEAD) || (state_q == ST_M_HIGH) ||
                    (state_q == ST_M_LOW)  || (state_q == ST_M_TAIL);
        run      = mst_state;
        slave_on = (state_q == ST_S_SEL);
        busy     = mst_state || (slave_on && bit_cnt_q != '0);
        out_bit  = shreg_q[DATA_W-1];
    end
endmodule

// File: rtl/spi_duplex_ctrl.sv
module spi_duplex_ctrl
    import spi_duplex_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              mf_disable,
    input  logic              ss_out_en,
    input  logic              auto_ss,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              fault_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              busy,
    output logic              done,
    output logic              fault,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_n_i,
    output logic              ss_n_o,
    output logic              ss_n_oe
);
    logic [2:0] pins_sync;
    logic       s_sclk, s_ss_n, s_mosi;
    logic       role_master;
    logic       tick, run;
    logic       sclk_q, out_bit, slave_on;
    logic       fault_q;

    // bit 2: clock, bit 1: select (idles high), bit 0: data
    spi_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  ({sclk_i, ss_n_i, mosi_i}),
        .pin_sync(pins_sync)
    );

    assign s_sclk = pins_sync[2];
    assign s_ss_n = pins_sync[1];
    assign s_mosi = pins_sync[0];

    assign role_master = master_en & ~fault_q;

    // conflict detection: sticky, cleared by strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          fault_q <= 1'b0;
        else if (fault_clr)  fault_q <= 1'b0;
        else if (role_master && !mf_disable && !s_ss_n) fault_q <= 1'b1;
    end

    spi_rate_gen #(.DIV_W(DIV_W)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div_sel(div_sel),
        .tick   (tick)
    );

    spi_ctrl_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_master(role_master),
        .start    (start),
        .tx_byte  (tx_byte),
        .tick     (tick),
        .miso_i   (miso_i),
        .sel_act  (~s_ss_n),
        .s_sclk   (s_sclk),
        .s_mosi   (s_mosi),
        .run      (run),
        .busy     (busy),
        .done     (done),
        .sclk_q   (sclk_q),
        .out_bit  (out_bit),
        .slave_on (slave_on),
        .rx_byte  (rx_byte)
    );

    always_comb begin
        fault   = fault_q;
        sclk_oe = role_master;
        sclk_o  = role_master & sclk_q;
        mosi_oe = role_master;
        mosi_o  = role_master & out_bit;
        miso_oe = slave_on;
        miso_o  = slave_on & out_bit;
        ss_n_oe = role_master & mf_disable & ss_out_en;
        if (ss_n_oe) ss_n_o = auto_ss ? ~run : 1'b0;
        else         ss_n_o = 1'b1;
    end
endmodule

// File: rtl/spi_duplex_chk.sv
module spi_duplex_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic fault,
    input logic fault_clr,
    input logic mf_disable,
    input logic auto_ss,
    input logic sclk_o,
    input logic sclk_oe,
    input logic mosi_o,
    input logic mosi_oe,
    input logic miso_oe,
    input logic ss_n_o,
    input logic ss_n_oe
);
    // R1
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_oe && !busy |-> !sclk_o);

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_oe && sclk_o && $past(sclk_o) && $past(sclk_oe) |-> $stable(mosi_o));

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_oe && $past(sclk_oe) && $fell(busy) |-> done);

    // R6
    miso_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !sclk_oe);

    // R8
    no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mf_disable && !fault |=> !fault);

    // R9
    fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault && !fault_clr |=> !sclk_oe && !mosi_oe && !ss_n_oe);

    // R10
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault && !fault_clr |=> fault);

    // R12
    ss_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && ss_n_oe && auto_ss |-> ss_n_o);
endmodule

bind spi_duplex_ctrl spi_duplex_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .fault     (fault),
    .fault_clr (fault_clr),
    .mf_disable(mf_disable),
    .auto_ss   (auto_ss),
    .sclk_o    (sclk_o),
    .sclk_oe   (sclk_oe),
    .mosi_o    (mosi_o),
    .mosi_oe   (mosi_oe),
    .miso_oe   (miso_oe),
    .ss_n_o    (ss_n_o),
    .ss_n_oe   (ss_n_oe)
);

// File: tb/spi_duplex_ctrl_test.sv
`timescale 1ns/1ps
module spi_duplex_ctrl_test;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 3;
    localparam int HS     = 8;

    typedef struct packed {
        logic [7:0] tx;
        logic [7:0] reply;
        logic [2:0] div;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 8'h3C, 3'd0},
        '{8'h00, 8'hFF, 3'd1},
        '{8'hFF, 8'h00, 3'd2},
        '{8'h81, 8'h7E, 3'd0},
        '{8'h5A, 8'hC3, 3'd3},
        '{8'h01, 8'h80, 3'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_en = 1'b1, mf_disable = 1'b1, ss_out_en = 1'b1, auto_ss = 1'b1;
    logic [DIV_W-1:0] div_sel = '0;
    logic start = 1'b0, fault_clr = 1'b0;
    logic [7:0] tx_byte = '0;
    logic [7:0] rx_byte;
    logic busy, done, fault;
    logic sclk_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
    logic sclk_o, sclk_oe, mosi_o, mosi_oe, miso_i, miso_o, miso_oe, ss_n_o, ss_n_oe;

    int n_chk = 0, n_bad = 0, done_cnt = 0, rise_cnt = 0;
    bit finished = 0;
    logic [7:0] mdl_sh = '0;
    logic mdl_cap = 1'b0;

    always #5 clk = ~clk;

    spi_duplex_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .mf_disable(mf_disable),
        .ss_out_en(ss_out_en), .auto_ss(auto_ss), .div_sel(div_sel), .start(start),
        .tx_byte(tx_byte), .fault_clr(fault_clr), .rx_byte(rx_byte), .busy(busy),
        .done(done), .fault(fault), .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i),
        .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i), .ss_n_o(ss_n_o),
        .ss_n_oe(ss_n_oe)
    );

    // external slave model on the master-role pins
    assign miso_i = mdl_sh[7];
    always @(posedge sclk_o) begin
        mdl_cap  <= mosi_o;
        rise_cnt <= rise_cnt + 1;
    end
    always @(negedge sclk_o) mdl_sh <= {mdl_sh[6:0], mdl_cap};

    always @(posedge clk) if (rst_n && done) done_cnt <= done_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start(input logic [7:0] b);
        @(negedge clk);
        tx_byte = b;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
    endtask

    // runs one master byte, returns busy cycle count and ss level seen mid-transfer
    task automatic master_xfer(input logic [7:0] b, input logic [7:0] reply,
                               input logic [2:0] dv, output int busy_cyc,
                               output logic ss_mid);
        int guard = 0;
        div_sel  = dv;
        mdl_sh   = reply;
        rise_cnt = 0;
        busy_cyc = 0;
        ss_mid   = 1'b1;
        pulse_start(b);
        while (!done && guard < 2000) begin
            if (busy) busy_cyc++;
            if (busy_cyc == 2) ss_mid = ss_n_o;
            guard++;
            @(negedge clk);
        end
        // sampled in the done cycle
        if (auto_ss && ss_n_oe) chk("R12 ss high in done cycle", ss_n_o, 1'b1);
        chk("R4 done pulse seen", done, 1'b1);
        wait_clk(1);
        chk("R4 done lasts one cycle", done, 1'b0);
    endtask

    task automatic slave_byte(input logic [7:0] mine, input logic [7:0] theirs,
                              output logic [7:0] seen);
        seen = '0;
        for (int i = 7; i >= 0; i--) begin
            mosi_i = theirs[i];
            wait_clk(HS);
            seen[i] = miso_o;
            sclk_i = 1'b1;
            wait_clk(HS);
            sclk_i = 1'b0;
        end
        wait_clk(HS);
        if (mine == 8'h00) seen = seen;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int bc;
        logic ssm;
        logic [7:0] seen;
        int dc0;

        // R14 reset state
        wait_clk(3);
        chk("R14 busy after reset", busy, 1'b0);
        chk("R14 done after reset", done, 1'b0);
        chk("R14 fault after reset", fault, 1'b0);
        chk("R14 rx after reset", rx_byte, 8'h00);
        chk("R14 ss_n_o after reset", ss_n_o, 1'b1);
        rst_n = 1'b1;
        wait_clk(4);

        // table walk: R1 R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            master_xfer(VECS[v].tx, VECS[v].reply, VECS[v].div, bc, ssm);
            chk("R4 received byte", rx_byte, VECS[v].reply);
            chk("R3 byte seen by bus slave", mdl_sh, VECS[v].tx);
            chk("R1 rising edge count", rise_cnt, 8);
            chk("R2 busy length", bc, 17 * (1 << VECS[v].div));
            chk("R12 ss low mid transfer", ssm, 1'b0);
            chk("R1 clock idles low", sclk_o, 1'b0);
            wait_clk(2);
        end

        // R12 idle level with auto select
        chk("R12 ss high while idle", ss_n_o, 1'b1);

        // R5 start during transfer ignored
        div_sel  = 3'd2;
        mdl_sh   = 8'h96;
        rise_cnt = 0;
        dc0      = done_cnt;
        pulse_start(8'h3E);
        wait_clk(12);
        pulse_start(8'hC1);
        chk("R5 busy held after second start", busy, 1'b1);
        wait_clk(80);
        chk("R5 single completion", done_cnt - dc0, 1);
        chk("R5 original byte sent", mdl_sh, 8'h3E);
        chk("R5 no extra edges", rise_cnt, 8);
        chk("R5 idle after byte", busy, 1'b0);

        // R11 select held low with auto off
        auto_ss = 1'b0;
        wait_clk(1);
        chk("R11 ss drive enabled", ss_n_oe, 1'b1);
        chk("R11 ss low while idle", ss_n_o, 1'b0);
        master_xfer(8'h42, 8'h24, 3'd0, bc, ssm);
        chk("R11 ss low during transfer", ssm, 1'b0);
        chk("R11 ss still low after", ss_n_o, 1'b0);
        auto_ss = 1'b1;

        // R8 select as general I/O
        ss_out_en = 1'b0;
        wait_clk(1);
        chk("R8 ss not driven", ss_n_oe, 1'b0);
        ss_n_i = 1'b0;
        wait_clk(6);
        chk("R8 no fault", fault, 1'b0);
        chk("R8 still master", sclk_oe, 1'b1);
        ss_n_i = 1'b1;
        wait_clk(4);

        // R9 conflict detection aborts transfer
        mf_disable = 1'b0;
        wait_clk(1);
        chk("R9 ss is input", ss_n_oe, 1'b0);
        dc0 = done_cnt;
        div_sel = 3'd2;
        pulse_start(8'h77);
        wait_clk(10);
        ss_n_i = 1'b0;
        wait_clk(3);
        chk("R9 fault set", fault, 1'b1);
        chk("R9 clock released", sclk_oe, 1'b0);
        chk("R9 mosi released", mosi_oe, 1'b0);
        ss_n_i = 1'b1;
        wait_clk(80);
        chk("R9 no done on abort", done_cnt - dc0, 0);

        // R10 sticky until cleared
        chk("R10 fault sticky", fault, 1'b1);
        @(negedge clk) fault_clr = 1'b1;
        @(negedge clk) fault_clr = 1'b0;
        chk("R10 fault cleared", fault, 1'b0);
        chk("R10 master restored", sclk_oe, 1'b1);

        // R13 start ignored without master role
        master_en = 1'b0;
        wait_clk(2);
        pulse_start(8'hAA);
        wait_clk(3);
        chk("R13 no busy in slave role", busy, 1'b0);
        chk("R13 no clock drive", sclk_oe, 1'b0);

        // R6 slave transfer
        mf_disable = 1'b1;
        tx_byte = 8'hB4;
        wait_clk(2);
        ss_n_i = 1'b0;
        wait_clk(5);
        chk("R6 miso driven when selected", miso_oe, 1'b1);
        dc0 = done_cnt;
        slave_byte(8'hB4, 8'h6D, seen);
        chk("R6 slave received", rx_byte, 8'h6D);
        chk("R6 slave sent", seen, 8'hB4);
        chk("R6 slave done", done_cnt - dc0, 1);
        ss_n_i = 1'b1;
        wait_clk(5);
        chk("R6 miso released", miso_oe, 1'b0);

        // R7 deselected slave ignores clock
        dc0 = done_cnt;
        slave_byte(8'hB4, 8'h11, seen);
        chk("R7 no done while deselected", done_cnt - dc0, 0);
        chk("R7 rx unchanged", rx_byte, 8'h6D);
        chk("R7 miso not driven", miso_oe, 1'b0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule